// File: doc/BRIEF.md
# Multi-Resolution PWM Analog Output Bank

This block drives four pulse-width-modulated outputs. Each output becomes a slowly varying analog voltage once it has passed through an external low-pass filter. A host writes one signed 16-bit voltage code per channel through a plain write strobe with an address and data. Code 0x7FFF stands for +10 V and code 0x8000 stands for -10 V. Each channel turns that code into the nearest duty cycle it can produce. Channel 0 is bipolar with 12-bit resolution and a period of 4096 clocks, which is 6 kHz from a 24.576 MHz clock. Channels 1 to 3 are unipolar (0 V to +10 V) with 8-bit resolution and a period of 256 clocks, which is 96 kHz.

A written code is converted to a duty value immediately and parked in a holding register. The active duty only changes when that channel's period counter wraps to zero, so a period in progress is never cut short. There is no handshake and no status: the host writes and forgets.

Top module: `pwm_out_bank`

## Requirements
- R1: While reset is held and in the first period after it, channel 0 outputs its zero-volt duty of 0x800 (high for counts 0 to 2047 of 4096), and channels 1 to 3 stay low.
- R2: Channel 0 repeats every 4096 clocks and channels 1 to 3 repeat every 256 clocks. All counters start at count 0 on the first clock after reset.
- R3: An output is high exactly while its period count is below the active duty. A duty of 0 keeps the output low for the whole period. Full scale (0xFFF or 0xFF) is high for every count except the last.
- R4: Channel 0 takes the code with its sign bit inverted (offset binary) and keeps bits [15:4]. It adds 1 when bit 3 is set and saturates at 0xFFF. Examples: 0x8000 gives 0x000, 0xFFFF gives 0x800, 0x0008 gives 0x801, 0x7FFF gives 0xFFF.
- R5: Channels 1 to 3 output duty 0 for any code with bit 15 set. For other codes they keep bits [14:7], add 1 when bit 6 is set, and saturate at 0xFF. Examples: 0x0040 gives 0x01, 0x003F gives 0x00, 0x4000 gives 0x80, 0x7FC0 gives 0xFF.
- R6: A write to address N (0 = bipolar channel, 1 to 3 = unipolar channels) changes only channel N.
- R7: A write captured at any count other than the last of a period leaves the rest of that period unchanged. The new duty starts at the next count 0.
- R8: A write captured on the clock edge where the counter wraps from its last count to 0 takes effect in the period that begins at that edge.
- R9: When several writes reach one channel within a period, only the last one is used at the next wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the period counters advance once per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one code per asserted cycle |
| wr_addr | input | 2 | Channel select: 0 bipolar, 1 to 3 unipolar |
| wr_data | input | 16 | Signed voltage code |
| pwm_o | output | 4 | PWM outputs, bit N is channel N |

## Verification
Two events can land on the same edge: a host write and a period wrap, where the holding value is copied into the active duty. To provoke this, the bench waits until the channel is on its last count and then issues the write, for the bipolar channel and for an unipolar one. It then checks that the duty of the very next period, measured cycle by cycle, is the newly written one and not the older held one. As a contrast, the bench also writes in the middle of a period and requires the old duty to run to the end of that period before the new one appears.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

    localparam int CODE_W = 16;

    typedef enum logic {
        KIND_BIPOLAR  = 1'b0,
        KIND_UNIPOLAR = 1'b1
    } chan_kind_e;

    typedef struct packed {
        logic              valid;
        logic [CODE_W-1:0] code;
    } chan_wr_t;

    // Converts a signed voltage code to a duty count of `res` bits,
    // rounding to the nearest level and saturating at full scale.
    function automatic logic [16:0] map_code(input logic [CODE_W-1:0] code,
                                             input int res,
                                             input chan_kind_e kind);
        logic [16:0] mag;
        logic [16:0] shifted;
        logic [16:0] trunc;
        logic [16:0] sum;
        logic [16:0] top;
        logic        rnd;
        top = (17'd1 << res) - 17'd1;
        if (kind == KIND_BIPOLAR) begin
            mag     = {1'b0, ~code[15], code[14:0]};
            shifted = mag >> (15 - res);
        end else begin
            mag     = {2'b00, code[14:0]};
            shifted = mag >> (14 - res);
        end
        rnd   = shifted[0];
        trunc = shifted >> 1;
        if (kind == KIND_UNIPOLAR && code[15]) begin
            trunc = '0;
            rnd   = 1'b0;
        end
        sum = trunc + {16'd0, rnd};
        if (sum > top) begin
            sum = top;
        end
        return sum;
    endfunction

endpackage

// File: rtl/pwm_code_map.sv
module pwm_code_map
    import pwm_bank_pkg::*;
#(
    parameter int         RES  = 8,
    parameter chan_kind_e KIND = KIND_UNIPOLAR
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [RES-1:0]    duty_o
);

    always_comb begin
        duty_o = RES'(map_code(code_i, RES, KIND));
    end

    // R5: a negative code can never raise a unipolar output
    always_comb begin
        if (KIND == KIND_UNIPOLAR && code_i[15]) begin
            p_neg_clamp_r5: assert (duty_o == '0)
                else $error("negative code mapped to nonzero duty");
        end
    end

    // R4: the most negative code is the bipolar floor
    always_comb begin
        if (KIND == KIND_BIPOLAR && code_i == 16'h8000) begin
            p_bip_floor_r4: assert (duty_o == '0)
                else $error("bipolar floor code mapped to nonzero duty");
        end
    end

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_bank_pkg::*;
#(
    parameter int         RES  = 8,
    parameter chan_kind_e KIND = KIND_UNIPOLAR
) (
    input  logic     clk,
    input  logic     rst,
    input  chan_wr_t wr_i,
    output logic     pwm_o
);

    localparam logic [RES-1:0] CNT_LAST  = '1;
    localparam logic [RES-1:0] IDLE_DUTY = RES'(map_code('0, RES, KIND));

    logic [RES-1:0] cnt;
    logic [RES-1:0] hold;
    logic [RES-1:0] active;
    logic [RES-1:0] new_duty;

    pwm_code_map #(
        .RES  (RES),
        .KIND (KIND)
    ) u_map (
        .code_i (wr_i.code),
        .duty_o (new_duty)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            hold   <= IDLE_DUTY;
            active <= IDLE_DUTY;
        end else begin
            cnt <= cnt + RES'(1);
            if (wr_i.valid) begin
                hold <= new_duty;
            end
            if (cnt == CNT_LAST) begin
                active <= wr_i.valid ? new_duty : hold;
            end
        end
    end

    assign pwm_o = (cnt < active);

    // R2: the counter wraps to zero after its last count
    p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        cnt == CNT_LAST |=> cnt == '0);

    // R7: the active duty never moves inside a period
    p_hold_mid_r7: assert property (@(posedge clk) disable iff (rst)
        cnt != '0 |-> active == $past(active));

    // R8: a write on the wrap edge goes straight to the active duty
    p_bypass_r8: assert property (@(posedge clk) disable iff (rst)
        (cnt == CNT_LAST && wr_i.valid) |=> active == $past(new_duty));

    // R3: the last count of a period is always low
    p_last_low_r3: assert property (@(posedge clk) disable iff (rst)
        cnt == CNT_LAST |-> !pwm_o);

    // R3: zero duty gives a low output
    p_zero_low_r3: assert property (@(posedge clk) disable iff (rst)
        active == '0 |-> !pwm_o);

endmodule

// File: rtl/pwm_out_bank.sv
module pwm_out_bank
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int HI_RES = 12,
    parameter int LO_RES = 8,
    localparam int ADDR_W = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CODE_W-1:0] wr_data,
    output logic [NUM_CH-1:0] pwm_o
);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        chan_wr_t req;
        assign req.valid = wr_en && (wr_addr == ADDR_W'(i));
        assign req.code  = wr_data;

        if (i == 0) begin : g_bipolar
            pwm_channel #(
                .RES  (HI_RES),
                .KIND (KIND_BIPOLAR)
            ) u_chan (
                .clk   (clk),
                .rst   (rst),
                .wr_i  (req),
                .pwm_o (pwm_o[i])
            );
        end else begin : g_unipolar
            pwm_channel #(
                .RES  (LO_RES),
                .KIND (KIND_UNIPOLAR)
            ) u_chan (
                .clk   (clk),
                .rst   (rst),
                .wr_i  (req),
                .pwm_o (pwm_o[i])
            );
        end
    end

endmodule

// File: tb/tb_pwm_out_bank.sv
`timescale 1ns/1ps
module tb_pwm_out_bank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  pwm_o;

    int checks = 0;
    int errors = 0;
    int t = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (rst) t <= 0;
        else     t <= t + 1;
    end

    pwm_out_bank dut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pwm_o   (pwm_o)
    );

    // {code, expected 12-bit duty, expected 8-bit duty}
    localparam int NV = 11;
    localparam logic [35:0] VEC [0:NV-1] = '{
        {16'h0000, 12'h800, 8'h00},
        {16'h7FFF, 12'hFFF, 8'hFF},
        {16'h8000, 12'h000, 8'h00},
        {16'hFFFF, 12'h800, 8'h00},
        {16'h0040, 12'h804, 8'h01},
        {16'h003F, 12'h804, 8'h00},
        {16'h4000, 12'hC00, 8'h80},
        {16'h1234, 12'h923, 8'h24},
        {16'h7FC0, 12'hFFC, 8'hFF},
        {16'hC000, 12'h400, 8'h00},
        {16'h0008, 12'h801, 8'h00}
    };

    task automatic chk(input bit ok, input string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s", msg);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic align(input int n, input int ph);
        while ((t % n) != ph) @(negedge clk);
    endtask

    // Starts at count 0 of channel 0 and checks one full 4096-cycle period
    task automatic check_period(input int e0, input int e1, input int e2, input int e3,
                                input string tag0, input string tag8);
        int bad [4];
        int hi [4];
        int ex [4];
        ex[0] = e0; ex[1] = e1; ex[2] = e2; ex[3] = e3;
        for (int c = 0; c < 4; c++) begin
            bad[c] = 0;
            hi[c]  = 0;
        end
        for (int ph = 0; ph < 4096; ph++) begin
            for (int c = 0; c < 4; c++) begin
                int p;
                p = (c == 0) ? ph : (ph % 256);
                if (pwm_o[c]) hi[c]++;
                if (pwm_o[c] !== (p < ex[c])) bad[c]++;
            end
            @(negedge clk);
        end
        chk(bad[0] == 0, $sformatf("%s ch0: high %0d of 4096, expected %0d (%0d bad cycles)",
                                   tag0, hi[0], ex[0], bad[0]));
        for (int c = 1; c < 4; c++) begin
            chk(bad[c] == 0, $sformatf("%s ch%0d: high %0d of 4096, expected %0d (%0d bad cycles)",
                                       tag8, c, hi[c], 16 * ex[c], bad[c]));
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int bad;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 R2 R3: reset state over the first full period
        check_period(12'h800, 0, 0, 0, "R1 R2", "R1 R2");

        // Vector table: same code to all channels mid-period, checked next period
        for (int i = 0; i < NV; i++) begin
            logic [15:0] code;
            code = VEC[i][35:20];
            for (int c = 0; c < 4; c++) wr(2'(c), code);
            align(4096, 0);
            check_period(int'(VEC[i][19:8]), int'(VEC[i][7:0]), int'(VEC[i][7:0]),
                         int'(VEC[i][7:0]),
                         $sformatf("R3 R4 code %h", code), $sformatf("R3 R5 code %h", code));
        end

        // R7: a mid-period write leaves the running period alone
        wr(2'd1, 16'h4000);
        align(256, 0);
        repeat (50) @(negedge clk);
        wr(2'd1, 16'h8000);
        bad = 0;
        for (int ph = 51; ph < 512; ph++) begin
            bit exp_hi;
            exp_hi = (ph < 256) ? (ph < 128) : 1'b0;
            if (pwm_o[1] !== exp_hi) bad++;
            @(negedge clk);
        end
        chk(bad == 0, $sformatf("R7 ch1 mid-period write: %0d bad cycles, expected 0", bad));

        // R6 R9: repeated writes to ch1, a single write to ch2, ch0/ch3 untouched
        align(4096, 0);
        wr(2'd1, 16'h7FFF);
        wr(2'd1, 16'h0040);
        wr(2'd2, 16'h4000);
        align(4096, 0);
        check_period(12'h801, 1, 8'h80, 0, "R6", "R6 R9");

        // R8: write on the wrap edge of an unipolar channel
        align(256, 255);
        wr(2'd3, 16'h4000);
        bad = 0;
        for (int ph = 0; ph < 256; ph++) begin
            if (pwm_o[3] !== (ph < 128)) bad++;
            @(negedge clk);
        end
        chk(bad == 0, $sformatf("R8 ch3 write on wrap: %0d bad cycles, expected 0", bad));

        // R8: write on the wrap edge of the bipolar channel (also R3 zero duty)
        align(4096, 4095);
        wr(2'd0, 16'h8000);
        check_period(0, 1, 8'h80, 8'h80, "R8 R3", "R8");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule